// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Front End

This block is the host-facing parallel port of a character display controller. A static protocol input chooses between two bus styles: a strobe style where one line carries read/write direction and a second, active-high enable line qualifies the cycle, and a split-strobe style with separate active-low write and read lines. A second static input chooses an 8-bit bus or a 4-bit bus. On the 4-bit bus each byte travels as two nibbles on the upper four data lines.

All bus inputs are synchronised to the core clock, and strobe edges are detected there. A completed write leaves the block as a single-cycle pulse that carries the byte and a flag telling whether it went to the instruction or the data register. Reads of the data register raise a single-cycle request toward a RAM access unit. That unit returns a byte on the cycle after the request, and the block holds it in an output buffer. The next read strobe drives that buffer onto the bus, so the first read after an address change gives back stale data. The block ignores every bus cycle made while chip select is inactive.

Top module: `hostbus_frontend`

## Requirements
- R1: While reset is active and right after it is released, `wr_valid`, `rd_req` and `db_oe` are low, and `db_out` is zero.
- R2: With `mode_68` high, `wide8` high and `cs_n` low, a falling edge of `e_rd` while `rw_wr` is low (write) produces `wr_valid` high for exactly one cycle. The pulse comes on the third rising clock edge after the falling edge. `wr_byte` equals `db_in` as it was during the strobe, and `wr_is_data` equals `rs` (low = instruction register, high = data register).
- R3: With `mode_68` low and `wide8` high, a rising edge of the active-low `rw_wr` (write strobe) while selected produces the same single-cycle pulse, with the same latency and the same byte and flag.
- R4: With `wide8` low, only `db_in[7:4]` is used. The first write strobe supplies bits 7..4 of the byte and the second supplies bits 3..0. Only the second strobe produces `wr_valid`, and `wr_is_data` comes from `rs` during the second strobe. `db_in[3:0]` has no effect.
- R5: After reset, the first nibble written on the 4-bit bus is taken as the upper nibble.
- R6: The end of a read strobe with `rs` high raises `rd_req` for exactly one cycle, three rising edges after the strobe ends. On the 8-bit bus every such read raises it. On the 4-bit bus only every second nibble read raises it. The read strobe is `e_rd` falling with `rw_wr` high in the strobe style, and `e_rd` rising in the split-strobe style.
- R7: The RAM unit places the byte on `rd_data` in the cycle after `rd_req`. Read strobes from then on drive that byte. Before the first request after reset, reads return zero.
- R8: On the 4-bit bus a read drives the buffer's bits 3..0 on `db_out[7:4]` during the first nibble read and bits 7..4 during the second. During 4-bit reads `db_out[3:0]` is zero.
- R9: A read with `rs` low raises no `rd_req`, does not advance the nibble order, and leaves the output buffer unchanged. The bus still shows the current buffer value.
- R10: While `cs_n` is high, strobes produce no `wr_valid`, no `rd_req` and no `db_oe`, and they do not advance the nibble order.
- R11: `db_oe` rises on the third rising edge after a read strobe becomes active while selected, and falls on the third edge after it ends. `db_out` is zero whenever `db_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mode_68 | input | 1 | Static protocol select: 1 = direction line plus enable strobe, 0 = split active-low strobes |
| wide8 | input | 1 | Static width select: 1 = 8-bit bus, 0 = 4-bit bus on upper lines |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 0 = instruction, 1 = data |
| rw_wr | input | 1 | Direction line (strobe style, low = write) or active-low write strobe |
| e_rd | input | 1 | Active-high enable (strobe style) or active-low read strobe |
| db_in | input | 8 | Data bus input lines |
| db_out | output | 8 | Data bus output value |
| db_oe | output | 1 | Data bus output enable |
| rd_data | input | 8 | Byte returned by the RAM unit the cycle after a request |
| wr_valid | output | 1 | One-cycle pulse: a complete byte was written |
| wr_byte | output | 8 | Written byte, valid with `wr_valid` |
| wr_is_data | output | 1 | Register flag of the written byte |
| rd_req | output | 1 | One-cycle read request toward the RAM unit |

## Verification
Each write result and each read request is due on the third rising edge after the strobe edge that ends the cycle. The bench drives on falling clock edges. It samples the pulse outputs on the second, third and fourth falling edges after the strobe ends, which confirms that a pulse is absent before its edge, present on it and gone after it. The output enable follows the same three-edge delay. Bus read data is sampled late inside each read strobe, and the idle gap between strobes is long enough for any byte requested earlier to have reached the output buffer.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Synchronised control lines of the host bus
    typedef struct packed {
        logic cs_n;
        logic rs;
        logic rw;      // direction line or write strobe
        logic st;      // enable line or read strobe
    } hb_ctl_t;

    // Idle value used while the synchronisers are in reset
    localparam hb_ctl_t HB_CTL_IDLE = '{cs_n: 1'b1, rs: 1'b0, rw: 1'b1, st: 1'b0};

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/hb_strobe_decode.sv
module hb_strobe_decode (
    input  logic mode_68,
    input  logic cs_n_prev,
    input  logic rw_prev,
    input  logic st_prev,
    input  logic cs_n_cur,
    input  logic rw_cur,
    input  logic st_cur,
    output logic wr_end,
    output logic rd_end,
    output logic rd_level
);

    logic sel_prev;
    logic en_fall;

    assign sel_prev = ~cs_n_prev;
    assign en_fall  = st_prev & ~st_cur;

    always_comb begin
        if (mode_68) begin
            wr_end   = sel_prev & en_fall & ~rw_prev;
            rd_end   = sel_prev & en_fall &  rw_prev;
            rd_level = ~cs_n_cur & st_cur & rw_cur;
        end else begin
            wr_end   = sel_prev & ~rw_prev & rw_cur;
            rd_end   = sel_prev & ~st_prev & st_cur;
            rd_level = ~cs_n_cur & ~st_cur;
        end
    end

endmodule

// File: rtl/hostbus_frontend.sv
module hostbus_frontend #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_68,
    input  logic          wide8,
    input  logic          cs_n,
    input  logic          rs,
    input  logic          rw_wr,
    input  logic          e_rd,
    input  logic [DW-1:0] db_in,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    input  logic [DW-1:0] rd_data,
    output logic          wr_valid,
    output logic [DW-1:0] wr_byte,
    output logic          wr_is_data,
    output logic          rd_req
);
    import hb_pkg::*;

    localparam int NW = DW / 2;

    typedef struct packed {
        hb_ctl_t       ctl_prev;
        logic [DW-1:0] dat_prev;
        logic          phase;     // 0: next nibble is first of a byte
        logic [NW-1:0] hold_hi;
        logic [DW-1:0] obuf;
        logic          rd_pend;
        logic          wr_valid;
        logic [DW-1:0] wr_byte;
        logic          wr_is_data;
        logic          rd_req;
        logic          oe;
    } fe_state_t;

    hb_ctl_t       ctl_raw;
    hb_ctl_t       ctl_s;
    logic [DW-1:0] dat_s;
    logic          wr_end;
    logic          rd_end;
    logic          rd_level;
    fe_state_t     st_d;
    fe_state_t     st_q;

    assign ctl_raw = '{cs_n: cs_n, rs: rs, rw: rw_wr, st: e_rd};

    hb_sync #(
        .W       ($bits(hb_ctl_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (HB_CTL_IDLE)
    ) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ctl_raw),
        .dout  (ctl_s)
    );

    hb_sync #(
        .W       (DW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync_dat (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (db_in),
        .dout  (dat_s)
    );

    hb_strobe_decode u_dec (
        .mode_68   (mode_68),
        .cs_n_prev (st_q.ctl_prev.cs_n),
        .rw_prev   (st_q.ctl_prev.rw),
        .st_prev   (st_q.ctl_prev.st),
        .cs_n_cur  (ctl_s.cs_n),
        .rw_cur    (ctl_s.rw),
        .st_cur    (ctl_s.st),
        .wr_end    (wr_end),
        .rd_end    (rd_end),
        .rd_level  (rd_level)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ctl_prev = ctl_s;
        st_d.dat_prev = dat_s;
        st_d.wr_valid = 1'b0;
        st_d.rd_req   = 1'b0;
        st_d.rd_pend  = st_q.rd_req;
        st_d.oe       = rd_level;

        if (st_q.rd_pend) begin
            st_d.obuf = rd_data;
        end

        if (wr_end) begin
            if (wide8) begin
                st_d.wr_valid   = 1'b1;
                st_d.wr_byte    = st_q.dat_prev;
                st_d.wr_is_data = st_q.ctl_prev.rs;
            end else if (!st_q.phase) begin
                st_d.hold_hi = st_q.dat_prev[DW-1:NW];
                st_d.phase   = 1'b1;
            end else begin
                st_d.wr_valid   = 1'b1;
                st_d.wr_byte    = {st_q.hold_hi, st_q.dat_prev[DW-1:NW]};
                st_d.wr_is_data = st_q.ctl_prev.rs;
                st_d.phase      = 1'b0;
            end
        end

        if (rd_end && st_q.ctl_prev.rs) begin
            if (wide8) begin
                st_d.rd_req = 1'b1;
            end else begin
                st_d.rd_req = st_q.phase;
                st_d.phase  = ~st_q.phase;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ctl_prev <= HB_CTL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    logic [DW-1:0] bus_val;

    always_comb begin
        if (wide8) begin
            bus_val = st_q.obuf;
        end else if (st_q.phase) begin
            bus_val = {st_q.obuf[DW-1:NW], {NW{1'b0}}};
        end else begin
            bus_val = {st_q.obuf[NW-1:0], {NW{1'b0}}};
        end
    end

    assign db_out     = st_q.oe ? bus_val : '0;
    assign db_oe      = st_q.oe;
    assign wr_valid   = st_q.wr_valid;
    assign wr_byte    = st_q.wr_byte;
    assign wr_is_data = st_q.wr_is_data;
    assign rd_req     = st_q.rd_req;

endmodule

// File: rtl/hostbus_frontend_chk.sv
module hostbus_frontend_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wide8,
    input logic          cs_n,
    input logic          wr_valid,
    input logic          rd_req,
    input logic          db_oe,
    input logic [DW-1:0] db_out
);
    localparam int NW = DW / 2;

    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    p_rd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_req));

    p_cs_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
        |-> (!wr_valid && !rd_req && !db_oe));

    p_low_lines_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide8 && db_oe) |-> (db_out[NW-1:0] == '0));

    p_bus_zero_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !db_oe |-> (db_out == '0));

endmodule

bind hostbus_frontend hostbus_frontend_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide8    (wide8),
    .cs_n     (cs_n),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .db_oe    (db_oe),
    .db_out   (db_out)
);

// File: tb/tb_hostbus_frontend.sv
module tb_hostbus_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_68 = 1'b0;
    logic       wide8 = 1'b1;
    logic       cs_n = 1'b1;
    logic       rs = 1'b0;
    logic       rw_wr = 1'b1;
    logic       e_rd = 1'b1;
    logic [7:0] db_in = 8'h00;
    logic [7:0] db_out;
    logic       db_oe;
    logic [7:0] rd_data;
    logic       wr_valid;
    logic [7:0] wr_byte;
    logic       wr_is_data;
    logic       rd_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int         nreq;
    logic [7:0] exp_buf;
    logic       ph;
    int         rd_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_frontend dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_68    (mode_68),
        .wide8      (wide8),
        .cs_n       (cs_n),
        .rs         (rs),
        .rw_wr      (rw_wr),
        .e_rd       (e_rd),
        .db_in      (db_in),
        .db_out     (db_out),
        .db_oe      (db_oe),
        .rd_data    (rd_data),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .wr_is_data (wr_is_data),
        .rd_req     (rd_req)
    );

    function automatic logic [7:0] ram_pat(input int n);
        return 8'(n * 37 + 11);
    endfunction

    // RAM model: returns the next pattern byte after each request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_cnt <= 0;
        else if (rd_req) rd_cnt <= rd_cnt + 1;
    end
    assign rd_data = ram_pat(rd_cnt);

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act %0d exp %0d", cyc, WATCHDOG);
            summary_and_end();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act %h exp %h (mode_68=%0b wide8=%0b)", tag, act, exp, mode_68, wide8);
        end
    endtask

    task automatic go_idle();
        cs_n = 1'b1;
        rs   = 1'b0;
        rw_wr = 1'b1;
        e_rd = mode_68 ? 1'b0 : 1'b1;
    endtask

    task automatic do_reset(input logic m68, input logic w8);
        @(negedge clk);
        rst_n   = 1'b0;
        mode_68 = m68;
        wide8   = w8;
        go_idle();
        repeat (3) @(negedge clk);
        check("R1 wr_valid in reset", {31'd0, wr_valid}, 32'd0);
        check("R1 db_oe in reset", {31'd0, db_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 wr_valid after reset", {31'd0, wr_valid}, 32'd0);
        check("R1 rd_req after reset", {31'd0, rd_req}, 32'd0);
        check("R1 db_out after reset", {24'd0, db_out}, 32'd0);
        nreq    = 0;
        exp_buf = 8'h00;
        ph      = 1'b0;
    endtask

    task automatic bus_write(input string tag, input logic r, input logic [7:0] d,
                             input logic csel, input logic exp_pulse,
                             input logic [7:0] exp_byte, input logic exp_rs);
        @(negedge clk);
        cs_n  = ~csel;
        rs    = r;
        db_in = d;
        if (mode_68) rw_wr = 1'b0;
        repeat (2) @(negedge clk);
        if (mode_68) e_rd = 1'b1; else rw_wr = 1'b0;
        repeat (4) @(negedge clk);
        if (mode_68) e_rd = 1'b0; else rw_wr = 1'b1;
        repeat (2) @(negedge clk);
        if (mode_68) rw_wr = 1'b1;
        check({tag, " pulse early"}, {31'd0, wr_valid}, 32'd0);
        @(negedge clk);
        check({tag, " pulse"}, {31'd0, wr_valid}, {31'd0, exp_pulse});
        if (exp_pulse) begin
            check({tag, " byte"}, {24'd0, wr_byte}, {24'd0, exp_byte});
            check({tag, " reg flag"}, {31'd0, wr_is_data}, {31'd0, exp_rs});
        end
        @(negedge clk);
        check({tag, " pulse width"}, {31'd0, wr_valid}, 32'd0);
        go_idle();
        db_in = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input string tag_bus, input string tag_req, input logic r,
                            input logic csel, input logic exp_oe,
                            input logic [7:0] exp_bus, input logic exp_req);
        @(negedge clk);
        cs_n  = ~csel;
        rs    = r;
        db_in = 8'h00;
        rw_wr = 1'b1;
        repeat (2) @(negedge clk);
        e_rd = mode_68 ? 1'b1 : 1'b0;
        repeat (2) @(negedge clk);
        check("R11 oe before third edge", {31'd0, db_oe}, 32'd0);
        @(negedge clk);
        check("R11 oe on third edge", {31'd0, db_oe}, {31'd0, exp_oe});
        repeat (2) @(negedge clk);
        check({tag_bus, " bus value"}, {24'd0, db_out}, {24'd0, exp_bus});
        e_rd = mode_68 ? 1'b0 : 1'b1;
        repeat (2) @(negedge clk);
        check({tag_req, " request early"}, {31'd0, rd_req}, 32'd0);
        check("R11 oe held", {31'd0, db_oe}, {31'd0, exp_oe});
        @(negedge clk);
        check({tag_req, " request"}, {31'd0, rd_req}, {31'd0, exp_req});
        check("R11 oe released", {31'd0, db_oe}, 32'd0);
        @(negedge clk);
        check({tag_req, " request width"}, {31'd0, rd_req}, 32'd0);
        go_idle();
        repeat (3) @(negedge clk);
    endtask

    // 8-bit data read with model update
    task automatic read8(input string tag_bus);
        bus_read(tag_bus, "R6", 1'b1, 1'b1, 1'b1, exp_buf, 1'b1);
        nreq    = nreq + 1;
        exp_buf = ram_pat(nreq);
    endtask

    // 4-bit data read with model update
    task automatic read4(input string tag_bus);
        logic [7:0] shown;
        shown = ph ? {exp_buf[7:4], 4'h0} : {exp_buf[3:0], 4'h0};
        bus_read(tag_bus, "R6", 1'b1, 1'b1, 1'b1, shown, ph);
        if (ph) begin
            nreq    = nreq + 1;
            exp_buf = ram_pat(nreq);
        end
        ph = ~ph;
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 2; w++) begin
                do_reset(m[0], w[0]);
                if (w == 1) begin
                    // byte writes over a sweep of values and both registers
                    for (int k = 0; k < 18; k++) begin
                        logic [7:0] b;
                        b = (k == 16) ? 8'h00 : (k == 17) ? 8'hFF : 8'(k * 29) ^ 8'hA5;
                        bus_write(m == 1 ? "R2" : "R3", k[0], b, 1'b1, 1'b1, b, k[0]);
                    end
                    bus_write("R10 deselected write", 1'b1, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0);
                    // reads: first returns reset buffer, then RAM bytes in order
                    read8("R7 first read");
                    bus_read("R9", "R9", 1'b0, 1'b1, 1'b1, exp_buf, 1'b0);
                    for (int k = 0; k < 4; k++) read8("R7");
                    bus_read("R10", "R10", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
                    read8("R7 after deselected read");
                end else begin
                    // nibble writes: upper first, low data lines carry junk
                    for (int k = 0; k < 16; k++) begin
                        logic [7:0] b;
                        b = 8'(k * 23 + 7);
                        bus_write(k == 0 ? "R5" : "R4", ~k[0], {b[7:4], 4'hA}, 1'b1,
                                  1'b0, 8'h00, 1'b0);
                        bus_write("R4", k[0], {b[3:0], 4'h5}, 1'b1, 1'b1, b, k[0]);
                    end
                    // deselected nibble between the halves of a byte
                    bus_write("R4", 1'b0, 8'hC3, 1'b1, 1'b0, 8'h00, 1'b0);
                    bus_write("R10 deselected nibble", 1'b1, 8'h70, 1'b0, 1'b0, 8'h00, 1'b0);
                    bus_write("R10", 1'b1, 8'h9F, 1'b1, 1'b1, 8'hC9, 1'b1);
                    // nibble reads: low half first, then high half
                    read4("R8 first low nibble");
                    bus_read("R9", "R9", 1'b0, 1'b1, 1'b1, {exp_buf[7:4], 4'h0}, 1'b0);
                    read4("R8 first high nibble");
                    for (int k = 0; k < 6; k++) read4(k[0] ? "R8 high" : "R7 low");
                    bus_read("R10", "R10", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
                    read4("R8 after deselected read");
                    read4("R8");
                end
            end
        end
        summary_and_end();
    end

endmodule